// File: doc/BRIEF.md
# I2C Control and Status Register

This block is the control and status register of a multi-master I2C controller, as the CPU sees it through a simple register port. It holds the transfer mode and the serial output enable. A CPU write to the bus-condition bit does not store anything. When output is enabled and a master mode is chosen, the write becomes a one-cycle request to the bit engine: writing 1 requests a START and writing 0 requests a STOP.

The bit engine reports bus events through single-cycle inputs. The block keeps these as sticky flags: arbitration lost, own-address match, zero (general-call) address, and the last bit received on the bus. Each flag has its own clearing rule. The busy bit is read straight from the bus-condition detector. A START in master transmit mode also raises a pulse that tells the data path to send the held byte without further software action.

Top module: `i2c_ctlstat_reg`

## Requirements
- R1: After reset, rdata reads 0 (with bus_busy at 0), and start_req, stop_req and tx_kick are 0.
- R2: A write (wr_en=1) stores wdata[7:6] as the mode (00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit) and wdata[4] as the output enable. Both are read back at the same bit positions, and both appear on the mode and out_en ports from the next cycle.
- R3: A write with wdata[4]=1 and wdata[7]=1 raises start_req (if wdata[5]=1) or stop_req (if wdata[5]=0) for exactly the one cycle after the write. start_req and stop_req are never high together.
- R4: A write with wdata[4]=0 or wdata[7]=0 raises neither start_req nor stop_req.
- R5: rdata[5] always equals the bus_busy input. The value written to bit 5 is never stored.
- R6: rdata[3] (arbitration lost) is set on the cycle after ev_arb_lost. It holds until a write with wdata[3]=0 clears it. A write with wdata[3]=1 leaves it unchanged. If the event and a clearing write arrive in the same cycle, the flag ends up set.
- R7: rdata[2] (address match) is set after ev_addr_match and cleared by a read (rd_en=1). The clearing read itself still returns 1. If the event and a read arrive in the same cycle, the flag ends up set. Writes do not change it.
- R8: rdata[1] (zero address) is set after ev_addr_zero and cleared after ev_bus_cond (a START or STOP seen on the bus). Reads and writes do not clear it. If set and clear arrive in the same cycle, the flag ends up set.
- R9: rdata[0] takes ev_rx_bit on the cycle after ev_rx_valid (0 = ACK, 1 = no ACK) and holds its value otherwise.
- R10: tx_kick pulses together with start_req exactly when the START-requesting write selects mode 11 (master transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |
| bus_busy | input | 1 | Bus busy from the bus-condition detector |
| ev_arb_lost | input | 1 | Arbitration-lost event |
| ev_addr_match | input | 1 | Received address equals own address |
| ev_addr_zero | input | 1 | Received address is all zeros |
| ev_bus_cond | input | 1 | START or STOP detected on the bus |
| ev_rx_valid | input | 1 | A received bit is valid this cycle |
| ev_rx_bit | input | 1 | Value of the received bit |
| mode | output | 2 | Current mode field |
| out_en | output | 1 | Serial output enable |
| start_req | output | 1 | One-cycle START request |
| stop_req | output | 1 | One-cycle STOP request |
| tx_kick | output | 1 | Send held byte (START in master transmit) |

## Verification
The hardest situations to reach are the same-cycle collisions between a flag's set event and its own clearing action. These are an arbitration loss during a write that clears bit 3, an address match during the read that clears it, and a zero-address event during a bus-condition event. Random stimulus seldom lines these up. Directed steps therefore drive each collision on purpose and then read the flag back. Around the directed steps, seeded random cycles mix writes, reads and events. A bench model predicts every output bit on every cycle.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;
    localparam int MODE_HI   = 7;
    localparam int MODE_LO   = 6;
    localparam int BUSY_BIT  = 5;
    localparam int OEN_BIT   = 4;
    localparam int ARB_BIT   = 3;
    localparam int MATCH_BIT = 2;
    localparam int ZERO_BIT  = 1;
    localparam int LAST_BIT  = 0;
    localparam int FIELD_W   = 8;

    typedef struct packed {
        logic [1:0] mode;
        logic       oen;
        logic       start;
        logic       stop;
        logic       kick;
    } ctrl_t;

    typedef struct packed {
        logic arb;
        logic match;
        logic zero;
        logic last;
    } flag_t;
endpackage

// File: rtl/i2c_cs_ctrl.sv
module i2c_cs_ctrl
    import i2c_cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wbyte,
    output ctrl_t              ctrl
);
    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        c_d.stop  = 1'b0;
        c_d.kick  = 1'b0;
        if (wr_en) begin
            c_d.mode = wbyte[MODE_HI:MODE_LO];
            c_d.oen  = wbyte[OEN_BIT];
            if (wbyte[OEN_BIT] && wbyte[MODE_HI]) begin
                c_d.start = wbyte[BUSY_BIT];
                c_d.stop  = !wbyte[BUSY_BIT];
                c_d.kick  = wbyte[BUSY_BIT] && wbyte[MODE_LO];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ctrl = c_q;

    p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_q.start && c_q.stop));
    p_req_needs_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.start || c_q.stop) |-> (c_q.oen && c_q.mode[1]));
    p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.start && !wr_en) |=> !c_q.start);
    p_kick_master_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.kick |-> (c_q.start && c_q.mode == 2'b11));
endmodule

// File: rtl/i2c_cs_flags.sv
module i2c_cs_flags
    import i2c_cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [FIELD_W-1:0] wbyte,
    input  logic               ev_arb_lost,
    input  logic               ev_addr_match,
    input  logic               ev_addr_zero,
    input  logic               ev_bus_cond,
    input  logic               ev_rx_valid,
    input  logic               ev_rx_bit,
    output flag_t              flags
);
    flag_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        // arbitration: software clear by writing 0, event wins
        if (wr_en && !wbyte[ARB_BIT]) f_d.arb = 1'b0;
        if (ev_arb_lost)              f_d.arb = 1'b1;
        // own-address match: cleared by a register read
        if (rd_en)                    f_d.match = 1'b0;
        if (ev_addr_match)            f_d.match = 1'b1;
        // zero address: cleared by a bus START/STOP
        if (ev_bus_cond)              f_d.zero = 1'b0;
        if (ev_addr_zero)             f_d.zero = 1'b1;
        // last received bit
        if (ev_rx_valid)              f_d.last = ev_rx_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    p_arb_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> f_q.arb);
    p_arb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.arb && !(wr_en && !wbyte[ARB_BIT])) |=> f_q.arb);
    p_match_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ev_addr_match) |=> !f_q.match);
    p_match_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_match |=> f_q.match);
    p_zero_bus_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bus_cond && !ev_addr_zero) |=> !f_q.zero);
    p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.zero && !ev_bus_cond) |=> f_q.zero);
    p_last_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_valid |=> (f_q.last == $past(ev_rx_bit)));
    p_last_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_rx_valid |=> $stable(f_q.last));
endmodule

// File: rtl/i2c_ctlstat_reg.sv
module i2c_ctlstat_reg
    import i2c_cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              bus_busy,
    input  logic              ev_arb_lost,
    input  logic              ev_addr_match,
    input  logic              ev_addr_zero,
    input  logic              ev_bus_cond,
    input  logic              ev_rx_valid,
    input  logic              ev_rx_bit,
    output logic [1:0]        mode,
    output logic              out_en,
    output logic              start_req,
    output logic              stop_req,
    output logic              tx_kick
);
    localparam int PAD_W = DATA_W - FIELD_W;

    logic [FIELD_W-1:0] wbyte;
    logic [FIELD_W-1:0] rbyte;
    ctrl_t              ctrl;
    flag_t              flags;

    assign wbyte = wdata[FIELD_W-1:0];

    i2c_cs_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wbyte (wbyte),
        .ctrl  (ctrl)
    );

    i2c_cs_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wbyte         (wbyte),
        .ev_arb_lost   (ev_arb_lost),
        .ev_addr_match (ev_addr_match),
        .ev_addr_zero  (ev_addr_zero),
        .ev_bus_cond   (ev_bus_cond),
        .ev_rx_valid   (ev_rx_valid),
        .ev_rx_bit     (ev_rx_bit),
        .flags         (flags)
    );

    always_comb begin
        rbyte                   = '0;
        rbyte[MODE_HI:MODE_LO]  = ctrl.mode;
        rbyte[BUSY_BIT]         = bus_busy;
        rbyte[OEN_BIT]          = ctrl.oen;
        rbyte[ARB_BIT]          = flags.arb;
        rbyte[MATCH_BIT]        = flags.match;
        rbyte[ZERO_BIT]         = flags.zero;
        rbyte[LAST_BIT]         = flags.last;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, rbyte};
        end else begin : g_nopad
            assign rdata = rbyte;
        end
    endgenerate

    assign mode      = ctrl.mode;
    assign out_en    = ctrl.oen;
    assign start_req = ctrl.start;
    assign stop_req  = ctrl.stop;
    assign tx_kick   = ctrl.kick;

    p_mode_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode == $past(wdata[MODE_HI:MODE_LO]) && out_en == $past(wdata[OEN_BIT])));
    p_busy_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUSY_BIT] == bus_busy);
endmodule

// File: tb/i2c_ctlstat_reg_test.sv
module i2c_ctlstat_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic bus_busy = 0, ev_arb_lost = 0, ev_addr_match = 0, ev_addr_zero = 0;
    logic ev_bus_cond = 0, ev_rx_valid = 0, ev_rx_bit = 0;
    logic [1:0] mode;
    logic out_en, start_req, stop_req, tx_kick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [1:0] m_mode = 0;
    logic m_oen = 0, m_start = 0, m_stop = 0, m_kick = 0;
    logic m_arb = 0, m_match = 0, m_zero = 0, m_last = 0;

    always #10 clk = ~clk;

    i2c_ctlstat_reg #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .bus_busy(bus_busy),
        .ev_arb_lost(ev_arb_lost), .ev_addr_match(ev_addr_match),
        .ev_addr_zero(ev_addr_zero), .ev_bus_cond(ev_bus_cond),
        .ev_rx_valid(ev_rx_valid), .ev_rx_bit(ev_rx_bit),
        .mode(mode), .out_en(out_en), .start_req(start_req),
        .stop_req(stop_req), .tx_kick(tx_kick)
    );

    function automatic logic [7:0] exp_rdata();
        return {m_mode, bus_busy, m_oen, m_arb, m_match, m_zero, m_last};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = exp_rdata();
        chk("R2 mode",   {6'b0, rdata[7:6]}, {6'b0, e[7:6]});
        chk("R2 out_en", {7'b0, rdata[4]},   {7'b0, e[4]});
        chk("R5 busy",   {7'b0, rdata[5]},   {7'b0, bus_busy});
        chk("R6 arb",    {7'b0, rdata[3]},   {7'b0, m_arb});
        chk("R7 match",  {7'b0, rdata[2]},   {7'b0, m_match});
        chk("R8 zero",   {7'b0, rdata[1]},   {7'b0, m_zero});
        chk("R9 last",   {7'b0, rdata[0]},   {7'b0, m_last});
        chk("R2 ports",  {5'b0, mode, out_en}, {5'b0, m_mode, m_oen});
        chk("R3 R4 start/stop", {6'b0, start_req, stop_req}, {6'b0, m_start, m_stop});
        chk("R10 kick",  {7'b0, tx_kick},    {7'b0, m_kick});
    endtask

    // Applies the currently driven inputs: checks outputs, advances model, steps one clock.
    task automatic step();
        #1;
        check_all();
        m_start = 0; m_stop = 0; m_kick = 0;
        if (wr_en) begin
            m_mode = wdata[7:6];
            m_oen  = wdata[4];
            if (wdata[4] && wdata[7]) begin
                m_start = wdata[5];
                m_stop  = !wdata[5];
                m_kick  = wdata[5] && wdata[6];
            end
            if (!wdata[3]) m_arb = 0;
        end
        if (ev_arb_lost) m_arb = 1;
        if (rd_en) m_match = 0;
        if (ev_addr_match) m_match = 1;
        if (ev_bus_cond) m_zero = 0;
        if (ev_addr_zero) m_zero = 1;
        if (ev_rx_valid) m_last = ev_rx_bit;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; ev_arb_lost = 0; ev_addr_match = 0;
        ev_addr_zero = 0; ev_bus_cond = 0; ev_rx_valid = 0; ev_rx_bit = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset rdata", rdata, 8'h00);
        chk("R1 reset pulses", {5'b0, start_req, stop_req, tx_kick}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        // directed: START in master transmit, then STOP
        idle(); wr_en = 1; wdata = 8'b1111_0000; step();
        idle(); step();
        chk("R10 kick seen", 8'(m_kick), 8'h0);
        idle(); wr_en = 1; wdata = 8'b1001_1000; step();
        idle(); step();
        // directed: slave mode / disabled writes give no request (R4)
        idle(); wr_en = 1; wdata = 8'b0111_1000; step();
        idle(); wr_en = 1; wdata = 8'b1110_1000; step();
        idle(); step();
        // R6 collision: event with clearing write
        idle(); ev_arb_lost = 1; step();
        idle(); wr_en = 1; wdata = 8'b0000_1000; step();
        idle(); wr_en = 1; wdata = 8'b0000_0000; ev_arb_lost = 1; step();
        idle(); step();
        idle(); wr_en = 1; wdata = 8'b0000_0000; step();
        idle(); step();
        // R7 collision: match with read; read returns 1 then clears
        idle(); ev_addr_match = 1; step();
        idle(); rd_en = 1; ev_addr_match = 1; step();
        idle(); rd_en = 1; step();
        idle(); step();
        // R8 collision and read-does-not-clear
        idle(); ev_addr_zero = 1; step();
        idle(); rd_en = 1; step();
        idle(); ev_bus_cond = 1; ev_addr_zero = 1; step();
        idle(); ev_bus_cond = 1; step();
        idle(); step();
        // R9 ACK / NACK
        idle(); ev_rx_valid = 1; ev_rx_bit = 1; step();
        idle(); ev_rx_bit = 0; step();
        idle(); ev_rx_valid = 1; ev_rx_bit = 0; step();
        idle(); step();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            idle();
            wr_en         = ($urandom % 4) == 0;
            rd_en         = ($urandom % 4) == 0;
            wdata         = 8'($urandom);
            bus_busy      = 1'($urandom);
            ev_arb_lost   = ($urandom % 8) == 0;
            ev_addr_match = ($urandom % 8) == 0;
            ev_addr_zero  = ($urandom % 8) == 0;
            ev_bus_cond   = ($urandom % 8) == 0;
            ev_rx_valid   = ($urandom % 4) == 0;
            ev_rx_bit     = 1'($urandom);
            step();
        end
        idle(); step();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule